// File: doc/BRIEF.md
# I/O Channel Device Directory

This block keeps a 256-entry device directory for every channel of one processor's channel group. An entry is chosen by channel number and 8-bit device address. It says whether a device is defined at that address, which control-word reference number serves it, and how the device may run: shared or private control word, forced selector operation, queued fast start, and data-streaming capability. One channel, number 5 by default, also has a per-entry byte/block flag.

A start request carries a channel and an address. One cycle later the block answers with the reference number, a condition code and the operating mode. The mode is chosen from a program-controlled block-multiplexing bit and the entry's own bits. An asynchronous status event from a device is answered in the same way with the control word to use for the interruption. Addresses with no defined device fall back to the channel's shared control word.

An operator edit port changes entries. Edits to the internal support devices take effect at once. All other edits are held in a small staging buffer and applied together when the configuration-reload pulse arrives.

Top module: `io_chan_directory`

## Requirements
- R1: After reset, every address except the native range is undefined. A start to such an address returns condition code 3 and reference number 32 + channel.
- R2: A response (`rsp_valid`) appears exactly one cycle after `req_valid`. A lookup made in the same cycle as a reload or an immediate edit sees the contents from before that change.
- R3: A start to a defined entry returns condition code 0 and the entry's stored reference number.
- R4: A start to an undefined entry returns condition code 3, mode 0, reference 32 + channel, and 0 on `rsp_qstart` and `rsp_stream`, whatever reference number is stored.
- R5: A defined entry runs in block-multiplexer mode (`rsp_mode` = 1) only when the mode bit is 1 and the entry's shared and selector-only bits are both 0. Otherwise it runs in selector mode (`rsp_mode` = 0). The mode bit in effect is the one held when the request is issued.
- R6: On channel 5, a defined entry with its byte flag set returns byte-multiplexer mode (`rsp_mode` = 2), which takes precedence over R5. On any other channel the byte flag has no effect.
- R7: The mode bit is 0 after reset. `mode_wr` loads it from `mode_val`. `boot_pulse` clears it to 0 and wins over a write in the same cycle.
- R8: A status event is answered on `evt_rsp_valid` one cycle later. The reference is the stored one if the entry is defined, and 32 + channel otherwise.
- R9: On channel 0, addresses F0 to FF hex are native. They reset as defined entries with reference 16 + (address − F0), all other flags 0. Edits to native entries never raise an error and are visible to a lookup issued the next cycle.
- R10: An edit to a non-native entry has no visible effect until `reload_pulse`. After the reload it is visible to lookups from the next cycle on. If several staged edits target one address, the latest wins.
- R11: A non-native edit that sets the defined bit with a reference number of 48 or less is rejected. `ed_err` goes high one cycle later and the entry never changes.
- R12: The staging buffer holds 8 edits. A non-native edit that arrives while it is full is rejected with `ed_err` and is lost. An edit in the same cycle as `reload_pulse` is accepted and held for the following reload.
- R13: `rsp_qstart` and `rsp_stream` return the queued-start and streaming bits of a defined entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_wr | input | 1 | Load the block-multiplexing mode bit |
| mode_val | input | 1 | Value for the mode bit |
| boot_pulse | input | 1 | Program load: clears the mode bit |
| reload_pulse | input | 1 | Configuration reload: applies staged edits |
| req_valid | input | 1 | Start request |
| req_ch | input | CH_W | Start request channel |
| req_addr | input | ADDR_W | Start request device address |
| rsp_valid | output | 1 | Start response valid |
| rsp_ref | output | REF_W | Control-word reference number |
| rsp_cc | output | 2 | Condition code: 0 started, 3 not operational |
| rsp_mode | output | 2 | 0 selector, 1 block multiplexer, 2 byte multiplexer |
| rsp_qstart | output | 1 | Entry allows queued fast start |
| rsp_stream | output | 1 | Entry is data-streaming capable |
| evt_valid | input | 1 | Asynchronous status event |
| evt_ch | input | CH_W | Event channel |
| evt_addr | input | ADDR_W | Event device address |
| evt_rsp_valid | output | 1 | Event response valid |
| evt_rsp_ref | output | REF_W | Control word for the interruption |
| ed_valid | input | 1 | Operator edit |
| ed_ch | input | CH_W | Edit channel |
| ed_addr | input | ADDR_W | Edit device address |
| ed_ref | input | REF_W | New reference number |
| ed_assigned | input | 1 | Device defined at this address |
| ed_shared | input | 1 | Shared control word |
| ed_selonly | input | 1 | Selector operation only |
| ed_qstart | input | 1 | Queued fast start allowed |
| ed_stream | input | 1 | Data-streaming capable |
| ed_bytemode | input | 1 | Byte-multiplexer flag, meaningful on channel 5 |
| ed_err | output | 1 | Edit rejected (one cycle after the edit) |

## Verification
On every cycle, the assertions check the fixed one-cycle latency of both lookup ports, that program load clears the mode bit, that block mode is reported only for started requests issued while the mode bit was set, that reserved-number and native edits raise the error flag as expected, and that the staging buffer stays within its bounds and empties on reload. Other properties depend on data held across many cycles, so only the bench's scenarios can show them. These are the fallback to the shared control word, the deferral of staged edits until reload, last-edit-wins ordering, the channel-5-only byte flag, and the lookup in a reload cycle seeing the old contents. The bench checks them against its own model of the directory under directed and random stimulus.

// File: rtl/chdir_pkg.sv
`timescale 1ns/1ps
package chdir_pkg;

  typedef struct packed {
    logic assigned;
    logic shared;
    logic selonly;
    logic qstart;
    logic stream;
    logic bytemode;
  } ent_flags_t;

  typedef enum logic [1:0] {
    MODE_SEL   = 2'd0,
    MODE_BLOCK = 2'd1,
    MODE_BYTE  = 2'd2
  } op_mode_e;

  localparam logic [1:0] CC_STARTED = 2'd0;
  localparam logic [1:0] CC_NOTOPER = 2'd3;

  // Operating mode: byte flag on the configurable channel first, then block
  // multiplexing gated by the program bit and the entry's capability bits.
  function automatic op_mode_e pick_mode(ent_flags_t f, logic blk_bit, logic cfg_ch);
    if (!f.assigned)              return MODE_SEL;
    if (cfg_ch && f.bytemode)     return MODE_BYTE;
    if (blk_bit && !f.shared && !f.selonly) return MODE_BLOCK;
    return MODE_SEL;
  endfunction

  function automatic logic [1:0] pick_cc(ent_flags_t f);
    return f.assigned ? CC_STARTED : CC_NOTOPER;
  endfunction

endpackage

// File: rtl/chdir_store.sv
`timescale 1ns/1ps
module chdir_store
  import chdir_pkg::*;
#(
  parameter int CH_W            = 3,
  parameter int ADDR_W          = 8,
  parameter int REF_W           = 11,
  parameter int PEND            = 8,
  parameter int SHARED_BASE     = 32,
  parameter int NATIVE_CH       = 0,
  parameter int NATIVE_LO       = 240,
  parameter int NATIVE_REF_BASE = 16,
  localparam int IDX_W = CH_W + ADDR_W,
  localparam int WORDS = 1 << IDX_W,
  localparam int FL_W  = $bits(ent_flags_t),
  localparam int ENT_W = REF_W + FL_W,
  localparam int CNT_W = $clog2(PEND + 1)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            q_en,
  input  logic [IDX_W-1:0]                q_idx,
  output logic [ENT_W-1:0]                q_word,
  input  logic                            e_en,
  input  logic [IDX_W-1:0]                e_idx,
  output logic [REF_W-1:0]                e_ref,
  output logic                            e_assigned,
  input  logic                            wr_en,
  input  logic [IDX_W-1:0]                wr_idx,
  input  logic [ENT_W-1:0]                wr_word,
  input  logic                            commit,
  input  logic [CNT_W-1:0]                commit_cnt,
  input  logic [PEND-1:0][IDX_W-1:0]      commit_idx,
  input  logic [PEND-1:0][ENT_W-1:0]      commit_word
);

  logic [ENT_W-1:0] mem [WORDS];

  // Reset image: native range preloaded, everything else points at the
  // channel-shared control word and is undefined.
  function automatic logic [ENT_W-1:0] init_word(int idx);
    int ch;
    int ad;
    ent_flags_t f;
    logic [REF_W-1:0] r;
    ch = idx >> ADDR_W;
    ad = idx & ((1 << ADDR_W) - 1);
    f  = '0;
    if (ch == NATIVE_CH && ad >= NATIVE_LO) begin
      f.assigned = 1'b1;
      r = REF_W'(NATIVE_REF_BASE + ad - NATIVE_LO);
    end else begin
      r = REF_W'(SHARED_BASE + ch);
    end
    return {r, f};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= init_word(i);
      q_word     <= '0;
      e_ref      <= '0;
      e_assigned <= 1'b0;
    end else begin
      // reads take the contents before this edge's writes
      if (q_en) q_word <= mem[q_idx];
      if (e_en) begin
        e_ref      <= mem[e_idx][ENT_W-1:FL_W];
        e_assigned <= mem[e_idx][FL_W-1];
      end
      if (commit) begin
        for (int i = 0; i < PEND; i++)
          if (i < int'(commit_cnt)) mem[commit_idx[i]] <= commit_word[i];
      end
      if (wr_en) mem[wr_idx] <= wr_word;
    end
  end

endmodule

// File: rtl/chdir_stage.sv
`timescale 1ns/1ps
module chdir_stage #(
  parameter int IDX_W = 11,
  parameter int ENT_W = 17,
  parameter int PEND  = 8,
  localparam int CNT_W = $clog2(PEND + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        push,
  input  logic [IDX_W-1:0]            push_idx,
  input  logic [ENT_W-1:0]            push_word,
  input  logic                        commit,
  output logic                        full,
  output logic [CNT_W-1:0]            cnt,
  output logic [PEND-1:0][IDX_W-1:0]  slot_idx,
  output logic [PEND-1:0][ENT_W-1:0]  slot_word
);

  assign full = (cnt == CNT_W'(PEND));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      slot_idx  <= '0;
      slot_word <= '0;
    end else if (commit) begin
      // buffer drains this edge; a same-cycle edit opens the next batch
      cnt <= push ? CNT_W'(1) : '0;
      if (push) begin
        slot_idx[0]  <= push_idx;
        slot_word[0] <= push_word;
      end
    end else if (push) begin
      for (int i = 0; i < PEND; i++)
        if (CNT_W'(i) == cnt) begin
          slot_idx[i]  <= push_idx;
          slot_word[i] <= push_word;
        end
      cnt <= cnt + CNT_W'(1);
    end
  end

  AST_STAGE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(PEND)); // R12
  AST_RELOAD_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
    commit && !push |=> cnt == '0); // R10

endmodule

// File: rtl/chdir_resolve.sv
`timescale 1ns/1ps
module chdir_resolve
  import chdir_pkg::*;
#(
  parameter int CH_W        = 3,
  parameter int REF_W       = 11,
  parameter int SHARED_BASE = 32,
  parameter int BYTE_CFG_CH = 5,
  localparam int FL_W  = $bits(ent_flags_t),
  localparam int ENT_W = REF_W + FL_W
) (
  input  logic [ENT_W-1:0] word,
  input  logic [CH_W-1:0]  ch,
  input  logic             blk_bit,
  output logic [REF_W-1:0] ref_num,
  output logic [1:0]       cc,
  output logic [1:0]       mode,
  output logic             qstart,
  output logic             stream
);

  ent_flags_t f;
  logic       cfg_ch;

  assign f       = ent_flags_t'(word[FL_W-1:0]);
  assign cfg_ch  = (ch == CH_W'(BYTE_CFG_CH));
  assign ref_num = f.assigned ? word[ENT_W-1:FL_W]
                              : REF_W'(SHARED_BASE) + REF_W'(ch);
  assign cc      = pick_cc(f);
  assign mode    = pick_mode(f, blk_bit, cfg_ch);
  assign qstart  = f.assigned & f.qstart;
  assign stream  = f.assigned & f.stream;

endmodule

// File: rtl/io_chan_directory.sv
`timescale 1ns/1ps
module io_chan_directory
  import chdir_pkg::*;
#(
  parameter int CH_W            = 3,
  parameter int ADDR_W          = 8,
  parameter int REF_W           = 11,
  parameter int PEND            = 8,
  parameter int RES_MAX         = 48,
  parameter int SHARED_BASE     = 32,
  parameter int NATIVE_CH       = 0,
  parameter int NATIVE_LO       = 240,
  parameter int NATIVE_REF_BASE = 16,
  parameter int BYTE_CFG_CH     = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_wr,
  input  logic              mode_val,
  input  logic              boot_pulse,
  input  logic              reload_pulse,
  input  logic              req_valid,
  input  logic [CH_W-1:0]   req_ch,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic [REF_W-1:0]  rsp_ref,
  output logic [1:0]        rsp_cc,
  output logic [1:0]        rsp_mode,
  output logic              rsp_qstart,
  output logic              rsp_stream,
  input  logic              evt_valid,
  input  logic [CH_W-1:0]   evt_ch,
  input  logic [ADDR_W-1:0] evt_addr,
  output logic              evt_rsp_valid,
  output logic [REF_W-1:0]  evt_rsp_ref,
  input  logic              ed_valid,
  input  logic [CH_W-1:0]   ed_ch,
  input  logic [ADDR_W-1:0] ed_addr,
  input  logic [REF_W-1:0]  ed_ref,
  input  logic              ed_assigned,
  input  logic              ed_shared,
  input  logic              ed_selonly,
  input  logic              ed_qstart,
  input  logic              ed_stream,
  input  logic              ed_bytemode,
  output logic              ed_err
);

  localparam int IDX_W = CH_W + ADDR_W;
  localparam int FL_W  = $bits(ent_flags_t);
  localparam int ENT_W = REF_W + FL_W;
  localparam int CNT_W = $clog2(PEND + 1);

  // ---- named internal events ----
  logic             blk_bit;
  logic             ed_native;
  logic             ed_reserved;
  logic             stage_push;
  logic             stage_full;
  logic             imm_wr;
  ent_flags_t       ed_flags;
  logic [ENT_W-1:0] ed_word;

  assign ed_native   = (ed_ch == CH_W'(NATIVE_CH)) && (ed_addr >= ADDR_W'(NATIVE_LO));
  assign ed_reserved = !ed_native && ed_assigned && (ed_ref <= REF_W'(RES_MAX));
  assign ed_flags    = '{ed_assigned, ed_shared, ed_selonly, ed_qstart, ed_stream, ed_bytemode};
  assign ed_word     = {ed_ref, ed_flags};
  assign imm_wr      = ed_valid && ed_native;
  assign stage_push  = ed_valid && !ed_native && !ed_reserved && (!stage_full || reload_pulse);

  // ---- mode bit ----
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          blk_bit <= 1'b0;
    else if (boot_pulse) blk_bit <= 1'b0;
    else if (mode_wr)    blk_bit <= mode_val;
  end

  // ---- response pipeline ----
  logic            rv_q, ev_q, err_q, blk_q;
  logic [CH_W-1:0] rch_q, ech_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rv_q <= 1'b0; ev_q <= 1'b0; err_q <= 1'b0; blk_q <= 1'b0;
      rch_q <= '0;  ech_q <= '0;
    end else begin
      rv_q  <= req_valid;
      ev_q  <= evt_valid;
      err_q <= ed_valid && !ed_native && (ed_reserved || (stage_full && !reload_pulse));
      if (req_valid) begin rch_q <= req_ch; blk_q <= blk_bit; end
      if (evt_valid) ech_q <= evt_ch;
    end
  end

  // ---- staging and storage ----
  logic [CNT_W-1:0]           pend_cnt;
  logic [PEND-1:0][IDX_W-1:0] pend_idx;
  logic [PEND-1:0][ENT_W-1:0] pend_word;
  logic [ENT_W-1:0]           rd_word;
  logic [REF_W-1:0]           ev_ref;
  logic                       ev_assigned;

  chdir_stage #(.IDX_W(IDX_W), .ENT_W(ENT_W), .PEND(PEND)) u_stage (
    .clk(clk), .rst_n(rst_n),
    .push(stage_push), .push_idx({ed_ch, ed_addr}), .push_word(ed_word),
    .commit(reload_pulse), .full(stage_full), .cnt(pend_cnt),
    .slot_idx(pend_idx), .slot_word(pend_word)
  );

  chdir_store #(
    .CH_W(CH_W), .ADDR_W(ADDR_W), .REF_W(REF_W), .PEND(PEND),
    .SHARED_BASE(SHARED_BASE), .NATIVE_CH(NATIVE_CH),
    .NATIVE_LO(NATIVE_LO), .NATIVE_REF_BASE(NATIVE_REF_BASE)
  ) u_store (
    .clk(clk), .rst_n(rst_n),
    .q_en(req_valid), .q_idx({req_ch, req_addr}), .q_word(rd_word),
    .e_en(evt_valid), .e_idx({evt_ch, evt_addr}), .e_ref(ev_ref), .e_assigned(ev_assigned),
    .wr_en(imm_wr), .wr_idx({ed_ch, ed_addr}), .wr_word(ed_word),
    .commit(reload_pulse), .commit_cnt(pend_cnt),
    .commit_idx(pend_idx), .commit_word(pend_word)
  );

  chdir_resolve #(
    .CH_W(CH_W), .REF_W(REF_W), .SHARED_BASE(SHARED_BASE), .BYTE_CFG_CH(BYTE_CFG_CH)
  ) u_resolve (
    .word(rd_word), .ch(rch_q), .blk_bit(blk_q),
    .ref_num(rsp_ref), .cc(rsp_cc), .mode(rsp_mode),
    .qstart(rsp_qstart), .stream(rsp_stream)
  );

  assign rsp_valid     = rv_q;
  assign evt_rsp_valid = ev_q;
  assign evt_rsp_ref   = ev_assigned ? ev_ref : REF_W'(SHARED_BASE) + REF_W'(ech_q);
  assign ed_err        = err_q;

  // ---- assertions ----
  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R2
  AST_EVT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |=> evt_rsp_valid); // R8
  AST_BOOT_CLEARS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    boot_pulse |=> !blk_bit); // R7
  AST_BLOCK_NEEDS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_mode == MODE_BLOCK |-> rsp_cc == CC_STARTED && blk_q); // R5
  AST_RESERVED_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    ed_valid && !ed_native && ed_assigned && ed_ref <= REF_W'(RES_MAX) |=> ed_err); // R11
  AST_NATIVE_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    ed_valid && ed_native |=> !ed_err); // R9

endmodule

// File: tb/tb_io_chan_directory.sv
`timescale 1ns/1ps
module tb_io_chan_directory;
  localparam int CH_W = 3, ADDR_W = 8, REF_W = 11, PEND = 8;
  localparam int WORDS = 1 << (CH_W + ADDR_W);

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, mode_wr, mode_val, boot_pulse, reload_pulse;
  logic req_valid; logic [CH_W-1:0] req_ch; logic [ADDR_W-1:0] req_addr;
  logic rsp_valid; logic [REF_W-1:0] rsp_ref; logic [1:0] rsp_cc, rsp_mode;
  logic rsp_qstart, rsp_stream;
  logic evt_valid; logic [CH_W-1:0] evt_ch; logic [ADDR_W-1:0] evt_addr;
  logic evt_rsp_valid; logic [REF_W-1:0] evt_rsp_ref;
  logic ed_valid; logic [CH_W-1:0] ed_ch; logic [ADDR_W-1:0] ed_addr; logic [REF_W-1:0] ed_ref;
  logic ed_assigned, ed_shared, ed_selonly, ed_qstart, ed_stream, ed_bytemode, ed_err;

  io_chan_directory dut (.*);

  int checks = 0, fails = 0;
  string tag = "";

  // model: flags [5]assigned [4]shared [3]selonly [2]qstart [1]stream [0]bytemode
  bit [REF_W-1:0] m_ref [WORDS];
  bit [5:0]       m_fl  [WORDS];
  int             p_idx [PEND];
  bit [REF_W-1:0] p_ref [PEND];
  bit [5:0]       p_fl  [PEND];
  int             p_cnt;
  bit             m_blk;

  bit e_rv, e_ev, e_err, e_fq, e_st;
  int e_ref, e_cc, e_mode, e_evref;

  task automatic chk(string what, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  function automatic bit is_native(int ch, int a);
    return ch == 0 && a >= 240;
  endfunction

  task automatic clear_inputs();
    mode_wr = 0; mode_val = 0; boot_pulse = 0; reload_pulse = 0;
    req_valid = 0; req_ch = 0; req_addr = 0;
    evt_valid = 0; evt_ch = 0; evt_addr = 0;
    ed_valid = 0; ed_ch = 0; ed_addr = 0; ed_ref = 0;
    {ed_assigned, ed_shared, ed_selonly, ed_qstart, ed_stream, ed_bytemode} = 6'b0;
  endtask

  task automatic req(int ch, int a);
    req_valid = 1; req_ch = CH_W'(ch); req_addr = ADDR_W'(a);
  endtask
  task automatic evt(int ch, int a);
    evt_valid = 1; evt_ch = CH_W'(ch); evt_addr = ADDR_W'(a);
  endtask
  task automatic edit(int ch, int a, int r, bit [5:0] fl);
    ed_valid = 1; ed_ch = CH_W'(ch); ed_addr = ADDR_W'(a); ed_ref = REF_W'(r);
    {ed_assigned, ed_shared, ed_selonly, ed_qstart, ed_stream, ed_bytemode} = fl;
  endtask

  // one clock: expectations from pre-edge model, model update, check at next negedge
  task automatic step();
    int idx;
    bit nat, resv;
    e_rv = req_valid; e_ev = evt_valid;
    if (req_valid) begin
      idx = int'(req_ch) * 256 + int'(req_addr);
      if (!m_fl[idx][5]) begin
        e_ref = 32 + int'(req_ch); e_cc = 3; e_mode = 0; e_fq = 0; e_st = 0;
      end else begin
        e_ref = m_ref[idx]; e_cc = 0; e_fq = m_fl[idx][2]; e_st = m_fl[idx][1];
        if (req_ch == 5 && m_fl[idx][0]) e_mode = 2;
        else if (m_blk && !m_fl[idx][4] && !m_fl[idx][3]) e_mode = 1;
        else e_mode = 0;
      end
    end
    if (evt_valid) begin
      idx = int'(evt_ch) * 256 + int'(evt_addr);
      e_evref = m_fl[idx][5] ? int'(m_ref[idx]) : 32 + int'(evt_ch);
    end
    nat  = is_native(int'(ed_ch), int'(ed_addr));
    resv = !nat && ed_assigned && ed_ref <= 48;
    e_err = ed_valid && !nat && (resv || (p_cnt == PEND && !reload_pulse));
    if (reload_pulse) begin
      for (int i = 0; i < p_cnt; i++) begin m_ref[p_idx[i]] = p_ref[i]; m_fl[p_idx[i]] = p_fl[i]; end
      p_cnt = 0;
    end
    if (ed_valid) begin
      idx = int'(ed_ch) * 256 + int'(ed_addr);
      if (nat) begin
        m_ref[idx] = ed_ref;
        m_fl[idx] = {ed_assigned, ed_shared, ed_selonly, ed_qstart, ed_stream, ed_bytemode};
      end else if (!resv && p_cnt < PEND) begin
        p_idx[p_cnt] = idx; p_ref[p_cnt] = ed_ref;
        p_fl[p_cnt] = {ed_assigned, ed_shared, ed_selonly, ed_qstart, ed_stream, ed_bytemode};
        p_cnt++;
      end
    end
    if (boot_pulse) m_blk = 0; else if (mode_wr) m_blk = mode_val;
    @(negedge clk);
    chk("rsp_valid R2", rsp_valid, e_rv);
    if (e_rv) begin
      chk("rsp_ref R3/R4", rsp_ref, e_ref);
      chk("rsp_cc R3/R4", rsp_cc, e_cc);
      chk("rsp_mode R5/R6", rsp_mode, e_mode);
      chk("rsp_qstart R13", rsp_qstart, e_fq);
      chk("rsp_stream R13", rsp_stream, e_st);
    end
    chk("evt_rsp_valid R8", evt_rsp_valid, e_ev);
    if (e_ev) chk("evt_rsp_ref R8", evt_rsp_ref, e_evref);
    chk("ed_err R11/R12", ed_err, e_err);
    clear_inputs();
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < WORDS; i++) begin
      int ch; int a;
      ch = i / 256; a = i % 256;
      if (is_native(ch, a)) begin m_fl[i] = 6'b100000; m_ref[i] = REF_W'(16 + a - 240); end
      else begin m_fl[i] = 0; m_ref[i] = REF_W'(32 + ch); end
    end
    p_cnt = 0; m_blk = 0;
    void'($urandom(32'd4381));
    clear_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    tag = "R1 reset";
    chk("rsp_valid R1", rsp_valid, 0);
    chk("ed_err R1", ed_err, 0);
    req(3, 8'h40); step();
    req(7, 8'h00); step();

    tag = "R9 native preload"; req(0, 8'hF3); step();
    tag = "R9 native immediate"; edit(0, 8'hF3, 200, 6'b100000); mode_wr = 1; mode_val = 1; step();
    tag = "R5 block mode"; req(0, 8'hF3); step();
    tag = "R5 shared forces selector"; edit(0, 8'hF4, 201, 6'b110000); step(); req(0, 8'hF4); step();

    tag = "R10 staged edit"; edit(2, 8'h10, 300, 6'b100110); step();
    req(2, 8'h10); step();
    tag = "R2 lookup in reload cycle"; reload_pulse = 1; req(2, 8'h10); step();
    tag = "R10 after reload R13"; req(2, 8'h10); step();
    tag = "R10 last wins";
    edit(2, 8'h12, 400, 6'b100000); step(); edit(2, 8'h12, 401, 6'b101000); step();
    reload_pulse = 1; step(); req(2, 8'h12); step();

    tag = "R11 reserved";
    edit(2, 8'h11, 40, 6'b100000); step(); edit(2, 8'h11, 48, 6'b100000); step();
    edit(2, 8'h11, 49, 6'b100000); step(); reload_pulse = 1; step(); req(2, 8'h11); step();

    tag = "R12 full";
    for (int i = 0; i < PEND; i++) begin edit(3, i, 100 + i, 6'b100000); step(); end
    edit(3, 8, 120, 6'b100000); step();
    edit(3, 9, 121, 6'b100000); reload_pulse = 1; step();
    req(3, 8); step(); req(3, 9); step(); req(3, 0); step();
    reload_pulse = 1; step(); req(3, 9); step(); req(3, 8); step();

    tag = "R6 byte channel";
    edit(5, 8'h20, 100, 6'b100001); step(); edit(4, 8'h20, 101, 6'b100001); step();
    reload_pulse = 1; step(); req(5, 8'h20); step(); req(4, 8'h20); step();

    tag = "R7 boot clears mode"; boot_pulse = 1; mode_wr = 1; mode_val = 1; step();
    req(0, 8'hF3); step();

    tag = "R8 events"; evt(4, 8'h99); step(); evt(2, 8'h10); step(); evt(0, 8'hF5); req(0, 8'hF5); step();

    tag = "random";
    for (int n = 0; n < 4000; n++) begin
      int ch; int a;
      if ($urandom % 10 < 7) begin
        ch = $urandom % 8; a = ($urandom % 4 == 0) ? 8'hF0 | ($urandom % 16) : $urandom % 8;
        req(ch, a);
      end
      if ($urandom % 5 == 0) begin
        ch = $urandom % 8; a = ($urandom % 4 == 0) ? 8'hF0 | ($urandom % 16) : $urandom % 8;
        evt(ch, a);
      end
      if ($urandom % 10 < 4) begin
        ch = ($urandom % 3 == 0) ? 0 : $urandom % 8;
        a = ($urandom % 4 == 0) ? 8'hF0 | ($urandom % 16) : $urandom % 8;
        edit(ch, a, ($urandom % 2) ? $urandom % 120 : 200 + $urandom % 1800, 6'($urandom));
      end
      if ($urandom % 25 == 0) reload_pulse = 1;
      if ($urandom % 60 == 0) boot_pulse = 1;
      if ($urandom % 8 == 0) begin mode_wr = 1; mode_val = 1'($urandom); end
      step();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule